// File: doc/BRIEF.md
# Remote Register Access Bridge

A local controller uses this block to reach a 32-bit register that sits on a separate remote register bus. It sees four local registers: a control word, a write-data holder, a read-data holder and a status word. The controller places the target address and a direction flag in the control word together with a busy flag. The bridge then runs one remote transaction. When the remote side responds, the bridge clears the busy flag. The controller learns that the access has finished by polling the control word until the busy bit reads back as zero.

On the remote side, the bridge presents a request with a valid/ready handshake and then waits for a single-cycle response strobe. The remote side may take any number of cycles to accept the request and any number to respond. A completed read copies the returned word into the read-data holder and raises a completion line on the block's signal vector. A control or write-data update that arrives while an access is still in flight is dropped and recorded in a sticky flag.

Top module: `reg_access_bridge`

## Requirements
- R1: A local write to the control word (select 0) with bit 31 set starts one remote transaction: `req_valid` rises on the next cycle, `req_addr` equals bits 29:0 of the written word, and `req_write` equals bit 30 (1 = write, 0 = read).
- R2: Bit 31 of the control word reads back as 1 from the cycle after the start until the cycle after `rsp_valid` is seen, and reads back as 0 after that.
- R3: For a write transaction, `req_wdata` carries the word previously stored through select 1.
- R4: For a read transaction, the `rsp_rdata` word seen with `rsp_valid` is stored and reads back through select 2. Local writes to select 2 have no effect.
- R5: Bit 6 of `done_sig` becomes 1 when a read completes. It returns to 0 when the next transaction starts. A completed write leaves it at 0, and all other bits of `done_sig` stay 0.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_write` and `req_wdata` hold their values. Only one transaction is outstanding at a time.
- R7: A write to select 0 or select 1 while bit 31 of the control word is set is ignored: the address, direction and write data stay unchanged. Such a write also sets the overrun flag, which reads back as bit 0 of select 3.
- R8: The overrun flag stays set across later transactions until any local write to select 3 clears it.
- R9: After reset, all four local registers read as 0, `req_valid` is 0 and `done_sig` is 0.
- R10: A write to select 0 with bit 31 clear loads the address and direction fields but starts no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_we | input | 1 | Local register write strobe |
| loc_sel | input | 2 | Local register select: 0 control, 1 write data, 2 read data, 3 status |
| loc_wdata | input | 32 | Local write value |
| loc_rdata | output | 32 | Value of the selected local register |
| req_valid | output | 1 | Remote request valid |
| req_ready | input | 1 | Remote request accepted |
| req_write | output | 1 | Remote request is a write |
| req_addr | output | 30 | Remote register address |
| req_wdata | output | 32 | Remote write value |
| rsp_valid | input | 1 | Remote response strobe |
| rsp_rdata | input | 32 | Remote read value |
| done_sig | output | 8 | Completion signal vector; bit 6 marks a finished read |

## Verification
Some behaviours are checked by assertions on every cycle:
- the request fields stay frozen while the remote side stalls;
- a second request never issues while a response is still owed;
- the completion bit only rises right after a read response;
- the overrun flag only changes after the local writes that are allowed to change it.

Other behaviours can only be shown by the bench's scenarios:
- the polled busy bit, seen as the controller sees it;
- the data carried in each direction under several latencies;
- an ignored command leaving the captured address and data untouched;
- a control write without the busy bit starting nothing.

// File: rtl/reg_access_pkg.sv
package reg_access_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_WDATA  = 2'd1;
    localparam logic [1:0] SEL_RDATA  = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;
endpackage

// File: rtl/rab_local_regs.sv
module rab_local_regs
    import reg_access_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AW = DATA_W - 2
) (
    input  logic              loc_we,
    input  logic [1:0]        loc_sel,
    input  logic              pend,
    input  logic              is_wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    input  logic              ovr,
    output logic              wr_ctrl,
    output logic              wr_wdata,
    output logic              wr_status,
    output logic [DATA_W-1:0] loc_rdata
);
    assign wr_ctrl   = loc_we && (loc_sel == SEL_CTRL);
    assign wr_wdata  = loc_we && (loc_sel == SEL_WDATA);
    assign wr_status = loc_we && (loc_sel == SEL_STATUS);

    always_comb begin
        unique case (loc_sel)
            SEL_CTRL:  loc_rdata = {pend, is_wr, addr};
            SEL_WDATA: loc_rdata = wdata;
            SEL_RDATA: loc_rdata = rdata;
            default:   loc_rdata = {{(DATA_W-1){1'b0}}, ovr};
        endcase
    end
endmodule

// File: rtl/rab_engine.sv
module rab_engine
    import reg_access_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AW = DATA_W - 2,
    localparam int PEND_BIT = DATA_W - 1,
    localparam int WR_BIT = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_wdata,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output phase_e            phase,
    output logic              pend,
    output logic              is_wr,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ovr,
    output logic              done
);
    typedef struct packed {
        phase_e            phase;
        logic              pend;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ovr;
        logic              done;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_status) begin
            st_d.ovr = 1'b0;
        end
        if (wr_ctrl) begin
            if (st_q.pend) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.addr = wr_value[AW-1:0];
                st_d.wr   = wr_value[WR_BIT];
                if (wr_value[PEND_BIT]) begin
                    st_d.pend  = 1'b1;
                    st_d.phase = PH_ISSUE;
                    st_d.done  = 1'b0;
                end
            end
        end
        if (wr_wdata) begin
            if (st_q.pend) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.wdata = wr_value;
            end
        end
        unique case (st_q.phase)
            PH_ISSUE: begin
                if (req_ready) begin
                    st_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    st_d.phase = PH_IDLE;
                    st_d.pend  = 1'b0;
                    if (!st_q.wr) begin
                        st_d.rdata = rsp_rdata;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign pend  = st_q.pend;
    assign is_wr = st_q.wr;
    assign addr  = st_q.addr;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;
    assign ovr   = st_q.ovr;
    assign done  = st_q.done;
endmodule

// File: rtl/reg_access_bridge.sv
module reg_access_bridge
    import reg_access_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SIG_W = 8,
    parameter int DONE_BIT = 6,
    localparam int AW = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_we,
    input  logic [1:0]        loc_sel,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [AW-1:0]     req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic [SIG_W-1:0]  done_sig
);
    phase_e            phase;
    logic              pend, is_wr, overrun, done;
    logic [AW-1:0]     addr;
    logic [DATA_W-1:0] wdata, rdata;
    logic              wr_ctrl, wr_wdata, wr_status;

    rab_local_regs #(.DATA_W(DATA_W)) u_regs (
        .loc_we    (loc_we),
        .loc_sel   (loc_sel),
        .pend      (pend),
        .is_wr     (is_wr),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .ovr       (overrun),
        .wr_ctrl   (wr_ctrl),
        .wr_wdata  (wr_wdata),
        .wr_status (wr_status),
        .loc_rdata (loc_rdata)
    );

    rab_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_wdata  (wr_wdata),
        .wr_status (wr_status),
        .wr_value  (loc_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .phase     (phase),
        .pend      (pend),
        .is_wr     (is_wr),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .ovr       (overrun),
        .done      (done)
    );

    assign req_valid = (phase == PH_ISSUE);
    assign req_write = is_wr;
    assign req_addr  = addr;
    assign req_wdata = wdata;

    for (genvar g = 0; g < SIG_W; g++) begin : g_sig
        if (g == DONE_BIT) begin : g_done
            assign done_sig[g] = done;
        end else begin : g_zero
            assign done_sig[g] = 1'b0;
        end
    end
endmodule

// File: rtl/reg_access_bridge_chk.sv
module reg_access_bridge_chk
    import reg_access_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SIG_W = 8,
    parameter int DONE_BIT = 6,
    localparam int AW = DATA_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_we,
    input logic [1:0]        loc_sel,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [SIG_W-1:0]  done_sig,
    input logic              overrun
);
    logic owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            owed_q <= 1'b1;
        end else if (rsp_valid) begin
            owed_q <= 1'b0;
        end
    end

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_write) && $stable(req_wdata)));

    // R6
    single_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q |-> !req_valid);

    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_sig[DONE_BIT]) |-> $past(rsp_valid && owed_q && !req_write));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(loc_we && (loc_sel == SEL_CTRL || loc_sel == SEL_WDATA)));

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $past(loc_we && loc_sel == SEL_STATUS));
endmodule

bind reg_access_bridge reg_access_bridge_chk #(
    .DATA_W(DATA_W), .SIG_W(SIG_W), .DONE_BIT(DONE_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_we    (loc_we),
    .loc_sel   (loc_sel),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .done_sig  (done_sig),
    .overrun   (overrun)
);

// File: tb/reg_access_bridge_test.sv
`timescale 1ns/1ps
module reg_access_bridge_test;
    typedef struct packed {
        logic        wr;
        logic [29:0] addr;
        logic [31:0] data;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 30'h0000_0003, 32'h1111_2222, 4'd0},
        '{1'b1, 30'h1234_5675, 32'hDEAD_BEEF, 4'd3},
        '{1'b0, 30'h0000_0003, 32'h0,         4'd1},
        '{1'b0, 30'h0000_0005, 32'h0,         4'd5},
        '{1'b0, 30'h3FFF_FFF9, 32'h0,         4'd2},
        '{1'b1, 30'h2AAA_AAA9, 32'h0000_0000, 4'd7},
        '{1'b0, 30'h0000_0009, 32'h0,         4'd0},
        '{1'b0, 30'h0000_0008, 32'h0,         4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_we = 1'b0;
    logic [1:0]  loc_sel = 2'd0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [29:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic [7:0]  done_sig;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int n_req = 0;
    int hold_bad = 0;
    logic [29:0] cap_addr;
    logic        cap_wr;
    logic [31:0] cap_wd;
    logic [31:0] mem [16];
    logic [31:0] exp_mem [16];

    always #2.5 clk = ~clk;

    reg_access_bridge uut (
        .clk(clk), .rst_n(rst_n), .loc_we(loc_we), .loc_sel(loc_sel),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .done_sig(done_sig)
    );

    // remote register model
    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + i;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            req_ready = 1'b0;
            if (rst_n && req_valid) begin
                logic [29:0] a0;
                a0 = req_addr;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!req_valid || req_addr != a0) hold_bad++;
                end
                req_ready = 1'b1;
                cap_addr = req_addr;
                cap_wr = req_write;
                cap_wd = req_wdata;
                @(negedge clk);
                req_ready = 1'b0;
                for (int k = 0; k < lat; k++) @(negedge clk);
                rsp_rdata = mem[cap_addr[3:0]];
                if (cap_wr) mem[cap_addr[3:0]] = cap_wd;
                rsp_valid = 1'b1;
                n_req++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        loc_we = 1'b1;
        loc_sel = s;
        loc_wdata = d;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        loc_sel = s;
        #1;
        d = loc_rdata;
    endtask

    task automatic poll_done(input string req);
        logic [31:0] v;
        int polls;
        polls = 0;
        reg_rd(2'd0, v);
        check(v[31] == 1'b1, req, {31'b0, v[31]}, 32'd1);
        while (v[31] && polls < 200) begin
            reg_rd(2'd0, v);
            polls++;
        end
        check(v[31] == 1'b0, "R2", {31'b0, v[31]}, 32'd0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 16; i++) exp_mem[i] = 32'hA500_0000 + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        for (int s = 0; s < 4; s++) begin
            reg_rd(s[1:0], v);
            check(v == 32'h0, "R9", v, 32'h0);
        end
        check(req_valid == 1'b0, "R9", {31'b0, req_valid}, 32'h0);
        check(done_sig == 8'h0, "R9", {24'b0, done_sig}, 32'h0);

        // vector table: R1 R2 R3 R4 R5
        for (int n = 0; n < NV; n++) begin
            lat = int'(VEC[n].lat);
            base = n_req;
            if (VEC[n].wr) reg_wr(2'd1, VEC[n].data);
            reg_wr(2'd0, {1'b1, VEC[n].wr, VEC[n].addr});
            poll_done("R2");
            check(n_req == base + 1, "R1", n_req, base + 1);
            check(cap_addr == VEC[n].addr, "R1", {2'b0, cap_addr}, {2'b0, VEC[n].addr});
            check(cap_wr == VEC[n].wr, "R1", {31'b0, cap_wr}, {31'b0, VEC[n].wr});
            if (VEC[n].wr) begin
                check(cap_wd == VEC[n].data, "R3", cap_wd, VEC[n].data);
                exp_mem[VEC[n].addr[3:0]] = VEC[n].data;
                check(done_sig == 8'h00, "R5", {24'b0, done_sig}, 32'h0);
            end else begin
                reg_rd(2'd2, v);
                check(v == exp_mem[VEC[n].addr[3:0]], "R4", v, exp_mem[VEC[n].addr[3:0]]);
                check(done_sig == 8'h40, "R5", {24'b0, done_sig}, 32'h40);
            end
        end
        check(hold_bad == 0, "R6", hold_bad, 0);

        // R4 write to read-data register ignored
        reg_rd(2'd2, v);
        reg_wr(2'd2, 32'h1234_0000);
        begin
            logic [31:0] v2;
            reg_rd(2'd2, v2);
            check(v2 == v, "R4", v2, v);
        end

        // R7 writes while busy are ignored and flagged
        lat = 20;
        reg_wr(2'd1, 32'h0000_5555);
        reg_wr(2'd0, 32'h8000_0002);
        reg_wr(2'd0, 32'hC000_0007);
        reg_wr(2'd1, 32'h0000_7777);
        poll_done("R2");
        check(cap_addr == 30'h2, "R7", {2'b0, cap_addr}, 32'h2);
        check(cap_wr == 1'b0, "R7", {31'b0, cap_wr}, 32'h0);
        reg_rd(2'd0, v);
        check(v == 32'h0000_0002, "R7", v, 32'h0000_0002);
        reg_rd(2'd1, v);
        check(v == 32'h0000_5555, "R7", v, 32'h0000_5555);
        reg_rd(2'd3, v);
        check(v == 32'h1, "R7", v, 32'h1);
        check(done_sig == 8'h40, "R5", {24'b0, done_sig}, 32'h40);

        // R8 sticky across another transaction, then cleared
        lat = 1;
        reg_wr(2'd0, 32'h8000_0004);
        poll_done("R2");
        reg_rd(2'd3, v);
        check(v == 32'h1, "R8", v, 32'h1);
        reg_wr(2'd3, 32'h0);
        reg_rd(2'd3, v);
        check(v == 32'h0, "R8", v, 32'h0);

        // R10 control write without busy bit starts nothing
        base = n_req;
        reg_wr(2'd0, 32'h4000_0011);
        repeat (6) @(negedge clk);
        check(n_req == base, "R10", n_req, base);
        check(req_valid == 1'b0, "R10", {31'b0, req_valid}, 32'h0);
        reg_rd(2'd0, v);
        check(v == 32'h4000_0011, "R10", v, 32'h4000_0011);
        check(done_sig == 8'h40, "R5", {24'b0, done_sig}, 32'h40);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule